// File: doc/BRIEF.md
# Posted Write Buffer with Address Merging

This block sits between a bus master and a single-port memory controller. When it is enabled, master writes of one 32-bit word with per-byte enables go into a small FIFO. Each write is acknowledged as soon as the FIFO has a free slot. The FIFO then empties into memory, oldest entry first, whenever the memory port is not serving a read. A write to a word address that the FIFO already holds updates that entry in place. Enabled bytes replace the stored bytes, and the entry's byte-valid mask grows. Repeated writes to the same word therefore cost one slot and one memory write.

Reads are not held back by posted writes. When a read is granted the memory port, the block takes a snapshot of every byte the FIFO holds for that word. When the memory data returns, the block lays those bytes over it, so the master always sees its own latest writes without a flush. While the buffer is enabled, a waiting read wins the memory port over draining. When the buffer is disabled, leftover entries drain first, and new writes then go to memory in the same cycle they are acknowledged, ahead of reads.

Top module: `pwb_top`

## Requirements
- R1: With `buf_en` high and fewer than DEPTH entries held, a write is acknowledged (`m_wr_ready` high) in the cycle it is offered, whatever the state of `mem_gnt`.
- R2: With DEPTH entries held, `m_wr_ready` is low. It is high again in the cycle after a drain write is granted.
- R3: A write whose word address matches a held entry that is not being granted to memory in that cycle takes no new slot. The memory later receives one write for that word, with `mem_be` set to the OR of all the merged enables.
- R4: When merged writes enable the same byte, the most recently accepted value of that byte is the one written to memory.
- R5: Entries reach memory in acceptance order, each carrying its word address, data and byte mask. After draining, the memory image equals the result of applying every accepted write in order.
- R6: A write that matches the head entry in the cycle that entry is granted to memory goes into a new entry. Memory then sees two writes to that word: first the old bytes, then the new write with only its own byte mask.
- R7: Read data returned on `m_rd_rdata` equals the word as left by every write accepted before the read's grant cycle. For each byte, a buffered byte is returned in place of the memory byte.
- R8: With `buf_en` high, a waiting read is presented to memory (`mem_req` high, `mem_we` low) ahead of any held entry.
- R9: With `buf_en` low, held entries drain first. A new write is then acknowledged only in a cycle where it is presented to memory and granted, and it goes ahead of a waiting read.
- R10: Only one read is outstanding at a time. `m_rd_rvalid` rises exactly one cycle after the `mem_rvalid` that answers it.
- R11: After reset the FIFO is empty: `m_wr_ready` is high (when enabled), `mem_req` is low and `m_rd_rvalid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| buf_en | input | 1 | 1: post and merge writes, reads first; 0: pass-through |
| m_wr_valid | input | 1 | Master write offered |
| m_wr_addr | input | AW | Word address of the write |
| m_wr_data | input | 8*NB | Write data |
| m_wr_be | input | NB | Byte enables, bit b covers data bits 8b+7..8b |
| m_wr_ready | output | 1 | Write acknowledged this cycle when valid |
| m_rd_valid | input | 1 | Master read offered |
| m_rd_addr | input | AW | Word address of the read |
| m_rd_ready | output | 1 | Read granted to memory this cycle |
| m_rd_rvalid | output | 1 | Merged read data valid |
| m_rd_rdata | output | 8*NB | Merged read data |
| mem_req | output | 1 | Memory command presented |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 8*NB | Memory write data |
| mem_be | output | NB | Memory byte mask |
| mem_gnt | input | 1 | Memory takes the presented command this cycle |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 8*NB | Memory read data |

## Verification
A wrong merge target or a lost slot shows up on the memory port within the drain time of the FIFO. The memory then receives an extra write, a missing write, or a byte mask that is wider or narrower than the accepted enables. A stale or misordered read snapshot shows up one cycle after the memory returns data, as a byte that differs from the scoreboard's running image of all accepted writes. A broken arbitration order shows up in the first cycle a read and a held entry compete, because the presented command has the wrong type. Random traffic over a few words, with an irregular grant, drives collisions between merge, drain and read. A final comparison of the memory image catches any write that was dropped.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_RD    = 2'd1,
    SEL_DRAIN = 2'd2,
    SEL_PASS  = 2'd3
  } mem_sel_e;
endpackage

// File: rtl/pwb_store.sv
// Entry store: shift-register FIFO (slot 0 oldest) with address match,
// in-place merge and a byte-wise lookup for read merging.
module pwb_store #(
  parameter int AW    = 16,
  parameter int DEPTH = 4,
  parameter int NB    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [AW-1:0]     push_addr,
  input  logic [8*NB-1:0]   push_data,
  input  logic [NB-1:0]     push_be,
  input  logic              pop,
  input  logic [AW-1:0]     look_addr,
  output logic              full,
  output logic              empty,
  output logic [AW-1:0]     head_addr,
  output logic [8*NB-1:0]   head_data,
  output logic [NB-1:0]     head_be,
  output logic [NB-1:0]     look_be,
  output logic [8*NB-1:0]   look_data
);
  localparam int DW = 8 * NB;
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] vld, vld_n;
  logic [AW-1:0]    ea   [DEPTH];
  logic [AW-1:0]    ea_n [DEPTH];
  logic [DW-1:0]    ed   [DEPTH];
  logic [DW-1:0]    ed_n [DEPTH];
  logic [NB-1:0]    eb   [DEPTH];
  logic [NB-1:0]    eb_n [DEPTH];

  logic [DEPTH-1:0] hit_vec;
  logic             hit;
  logic [IW-1:0]    hit_idx;
  logic [CW-1:0]    cnt;
  logic [IW-1:0]    tgt;

  // The head is not a merge target in the cycle it leaves for memory.
  for (genvar i = 0; i < DEPTH; i++) begin : g_hit
    assign hit_vec[i] = vld[i] && (ea[i] == push_addr) && ((i != 0) || !pop);
  end

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    cnt     = '0;
    for (int i = 0; i < DEPTH; i++) begin
      cnt = cnt + CW'(vld[i]);
      if (hit_vec[i]) begin
        hit     = 1'b1;
        hit_idx = IW'(i);
      end
    end
  end

  always_comb begin
    vld_n = vld;
    for (int i = 0; i < DEPTH; i++) begin
      ea_n[i] = ea[i];
      ed_n[i] = ed[i];
      eb_n[i] = eb[i];
    end
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        ea_n[i] = ea[i+1];
        ed_n[i] = ed[i+1];
        eb_n[i] = eb[i+1];
      end
      eb_n[DEPTH-1] = '0;
      vld_n = {1'b0, vld[DEPTH-1:1]};
    end
    tgt = hit ? (hit_idx - IW'(pop)) : (IW'(cnt) - IW'(pop));
    if (push) begin
      if (!hit) begin
        vld_n[tgt] = 1'b1;
        ea_n[tgt]  = push_addr;
        eb_n[tgt]  = '0;
      end
      for (int b = 0; b < NB; b++) begin
        if (push_be[b]) ed_n[tgt][8*b +: 8] = push_data[8*b +: 8];
      end
      eb_n[tgt] = eb_n[tgt] | push_be;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      for (int i = 0; i < DEPTH; i++) eb[i] <= '0;
    end else begin
      vld <= vld_n;
      for (int i = 0; i < DEPTH; i++) eb[i] <= eb_n[i];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      ea[i] <= ea_n[i];
      ed[i] <= ed_n[i];
    end
  end

  // Oldest to youngest, so a younger byte overrides an older one.
  always_comb begin
    look_be   = '0;
    look_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld[i] && (ea[i] == look_addr)) begin
        for (int b = 0; b < NB; b++) begin
          if (eb[i][b]) begin
            look_data[8*b +: 8] = ed[i][8*b +: 8];
            look_be[b]          = 1'b1;
          end
        end
      end
    end
  end

  assign full      = vld[DEPTH-1];
  assign empty     = !vld[0];
  assign head_addr = ea[0];
  assign head_data = ed[0];
  assign head_be   = eb[0];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) push |-> !full); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) pop |-> !empty); // R5
  AST_MERGE_NO_SLOT: assert property (@(posedge clk) disable iff (rst)
    (push && hit && !pop) |=> ($countones(vld) == $past($countones(vld)))); // R3
  for (genvar i = 0; i < DEPTH - 1; i++) begin : g_pack
    AST_PACKED: assert property (@(posedge clk) disable iff (rst) !vld[i] |-> !vld[i+1]); // R5
  end
endmodule

// File: rtl/pwb_arb.sv
// Memory port arbiter: the enable picks between read-first and write-first order.
module pwb_arb
  import pwb_pkg::*;
(
  input  logic     en,
  input  logic     rd_req,
  input  logic     wr_req,
  input  logic     empty,
  output mem_sel_e sel
);
  always_comb begin
    sel = SEL_NONE;
    if (en) begin
      if (rd_req)      sel = SEL_RD;
      else if (!empty) sel = SEL_DRAIN;
    end else begin
      if (!empty)      sel = SEL_DRAIN;
      else if (wr_req) sel = SEL_PASS;
      else if (rd_req) sel = SEL_RD;
    end
  end
endmodule

// File: rtl/pwb_rdmerge.sv
// Holds the buffered-byte snapshot of the one outstanding read and
// overlays it on the memory return data.
module pwb_rdmerge #(
  parameter int NB = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            grant,
  input  logic [NB-1:0]   grant_be,
  input  logic [8*NB-1:0] grant_data,
  input  logic            mem_rvalid,
  input  logic [8*NB-1:0] mem_rdata,
  output logic            busy,
  output logic            out_valid,
  output logic [8*NB-1:0] out_data
);
  localparam int DW = 8 * NB;

  logic [NB-1:0] snap_be;
  logic [DW-1:0] snap_d;
  logic [DW-1:0] merged;

  always_ff @(posedge clk) begin
    if (grant) begin
      snap_be <= grant_be;
      snap_d  <= grant_data;
    end
  end

  always_comb begin
    for (int b = 0; b < NB; b++)
      merged[8*b +: 8] = snap_be[b] ? snap_d[8*b +: 8] : mem_rdata[8*b +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (grant)           busy <= 1'b1;
      else if (mem_rvalid) busy <= 1'b0;
      out_valid <= mem_rvalid && busy;
      if (mem_rvalid) out_data <= merged;
    end
  end

  AST_ONE_READ: assert property (@(posedge clk) disable iff (rst) busy |-> !grant); // R10
  AST_RET_AFTER_MEM: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(mem_rvalid)); // R10
endmodule

// File: rtl/pwb_top.sv
module pwb_top
  import pwb_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DEPTH = 4,
  parameter int NB    = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            buf_en,
  input  logic            m_wr_valid,
  input  logic [AW-1:0]   m_wr_addr,
  input  logic [8*NB-1:0] m_wr_data,
  input  logic [NB-1:0]   m_wr_be,
  output logic            m_wr_ready,
  input  logic            m_rd_valid,
  input  logic [AW-1:0]   m_rd_addr,
  output logic            m_rd_ready,
  output logic            m_rd_rvalid,
  output logic [8*NB-1:0] m_rd_rdata,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [8*NB-1:0] mem_wdata,
  output logic [NB-1:0]   mem_be,
  input  logic            mem_gnt,
  input  logic            mem_rvalid,
  input  logic [8*NB-1:0] mem_rdata
);
  localparam int DW = 8 * NB;

  mem_sel_e      sel;
  logic          rd_busy, rd_req, push, pop, full, empty;
  logic [AW-1:0] head_addr;
  logic [DW-1:0] head_data, look_data;
  logic [NB-1:0] head_be, look_be;

  assign rd_req = m_rd_valid && !rd_busy;
  assign push   = buf_en && m_wr_valid && !full;
  assign pop    = (sel == SEL_DRAIN) && mem_gnt;

  pwb_arb u_arb (
    .en     (buf_en),
    .rd_req (rd_req),
    .wr_req (m_wr_valid),
    .empty  (empty),
    .sel    (sel)
  );

  pwb_store #(.AW(AW), .DEPTH(DEPTH), .NB(NB)) u_store (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_addr (m_wr_addr),
    .push_data (m_wr_data),
    .push_be   (m_wr_be),
    .pop       (pop),
    .look_addr (m_rd_addr),
    .full      (full),
    .empty     (empty),
    .head_addr (head_addr),
    .head_data (head_data),
    .head_be   (head_be),
    .look_be   (look_be),
    .look_data (look_data)
  );

  pwb_rdmerge #(.NB(NB)) u_rdm (
    .clk        (clk),
    .rst        (rst),
    .grant      (m_rd_ready),
    .grant_be   (look_be),
    .grant_data (look_data),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .busy       (rd_busy),
    .out_valid  (m_rd_rvalid),
    .out_data   (m_rd_rdata)
  );

  assign m_wr_ready = buf_en ? !full : ((sel == SEL_PASS) && mem_gnt);
  assign m_rd_ready = (sel == SEL_RD) && mem_gnt;
  assign mem_req    = (sel != SEL_NONE);
  assign mem_we     = (sel == SEL_DRAIN) || (sel == SEL_PASS);

  always_comb begin
    case (sel)
      SEL_RD: begin
        mem_addr = m_rd_addr; mem_wdata = '0;        mem_be = '1;
      end
      SEL_DRAIN: begin
        mem_addr = head_addr; mem_wdata = head_data; mem_be = head_be;
      end
      SEL_PASS: begin
        mem_addr = m_wr_addr; mem_wdata = m_wr_data; mem_be = m_wr_be;
      end
      default: begin
        mem_addr = '0;        mem_wdata = '0;        mem_be = '0;
      end
    endcase
  end

  AST_READ_FIRST: assert property (@(posedge clk) disable iff (rst)
    (buf_en && m_rd_valid && !rd_busy && mem_req) |-> !mem_we); // R8
  AST_PASS_DIRECT: assert property (@(posedge clk) disable iff (rst)
    (!buf_en && m_wr_valid && m_wr_ready) |-> (mem_we && mem_addr == m_wr_addr
                                               && mem_wdata == m_wr_data)); // R9
  AST_ACK_WHEN_ROOM: assert property (@(posedge clk) disable iff (rst)
    (buf_en && m_wr_valid && !full) |-> m_wr_ready); // R1
endmodule

// File: tb/tb_pwb_top.sv
`timescale 1ns/1ps
module tb_pwb_top;
  localparam int AW = 6, DEPTH = 4, NB = 4, LAT = 2, WORDS = 64;

  logic clk = 1'b0, rst = 1'b1, buf_en = 1'b1;
  logic m_wr_valid = 0, m_rd_valid = 0, mem_gnt = 0, mem_rvalid = 0;
  logic [AW-1:0] m_wr_addr = '0, m_rd_addr = '0;
  logic [31:0] m_wr_data = '0, mem_rdata = '0;
  logic [3:0] m_wr_be = '0;
  logic m_wr_ready, m_rd_ready, m_rd_rvalid, mem_req, mem_we;
  logic [31:0] m_rd_rdata, mem_wdata;
  logic [AW-1:0] mem_addr;
  logic [3:0] mem_be;

  pwb_top #(.AW(AW), .DEPTH(DEPTH), .NB(NB)) dut (
    .clk(clk), .rst(rst), .buf_en(buf_en),
    .m_wr_valid(m_wr_valid), .m_wr_addr(m_wr_addr), .m_wr_data(m_wr_data),
    .m_wr_be(m_wr_be), .m_wr_ready(m_wr_ready),
    .m_rd_valid(m_rd_valid), .m_rd_addr(m_rd_addr), .m_rd_ready(m_rd_ready),
    .m_rd_rvalid(m_rd_rvalid), .m_rd_rdata(m_rd_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  always #2 clk = ~clk;

  typedef struct { logic we; logic [AW-1:0] a; logic [31:0] d; logic [3:0] be; } cmd_t;
  cmd_t        cmd_log[$];
  logic [31:0] exp_q[$];
  logic [31:0] bmem [WORDS];
  logic [31:0] gold [WORDS];
  int n_chk = 0, n_fail = 0, cyc = 0, pend = 0, rv_cyc = 0;
  logic [31:0] pdata = '0;
  bit outstanding = 0;

  function automatic logic [31:0] apply(logic [31:0] old, logic [31:0] d, logic [3:0] be);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = d[8*b +: 8];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Memory model, scoreboard and monitor; samples 1.5 ns after each falling edge.
  initial begin
    for (int i = 0; i < WORDS; i++) begin
      bmem[i] = 32'h1000_0000 + i * 32'h0101_0101;
      gold[i] = bmem[i];
    end
    forever begin
      @(negedge clk);
      cyc++;
      mem_rvalid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin mem_rvalid = 1'b1; mem_rdata = pdata; end
      end
      #1.5;
      if (cyc > 150000) begin
        chk(0, "watchdog all-requirements", cyc, 150000);
        finish_run();
      end
      if (!rst) begin
        if (mem_rvalid) begin outstanding = 0; rv_cyc = cyc; end
        if (mem_req && mem_gnt) begin
          cmd_log.push_back('{mem_we, mem_addr, mem_wdata, mem_be});
          if (mem_we) bmem[mem_addr] = apply(bmem[mem_addr], mem_wdata, mem_be);
          else begin
            chk(!outstanding, "R10 single outstanding read", 1, 0);
            outstanding = 1; pend = LAT; pdata = bmem[mem_addr];
          end
        end
        if (m_rd_valid && m_rd_ready) exp_q.push_back(gold[m_rd_addr]);
        if (m_wr_valid && m_wr_ready) gold[m_wr_addr] = apply(gold[m_wr_addr], m_wr_data, m_wr_be);
        if (m_rd_rvalid) begin
          if (exp_q.size() == 0) chk(0, "R7 unexpected read data", m_rd_rdata, 0);
          else begin
            logic [31:0] e;
            e = exp_q.pop_front();
            chk(m_rd_rdata == e, "R7 merged read data", m_rd_rdata, e);
          end
          chk(cyc == rv_cyc + 1, "R10 return latency", cyc - rv_cyc, 1);
        end
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be);
    bit acc = 0;
    int k = 0;
    m_wr_valid = 1; m_wr_addr = a; m_wr_data = d; m_wr_be = be;
    while (!acc && k < 60) begin #1.5; acc = m_wr_ready; k++; @(negedge clk); end
    m_wr_valid = 0;
    if (!acc) chk(0, "R1 write acknowledged", 0, 1);
  endtask

  task automatic rd(input logic [AW-1:0] a);
    bit acc = 0;
    int k = 0;
    m_rd_valid = 1; m_rd_addr = a;
    while (!acc && k < 60) begin #1.5; acc = m_rd_ready; k++; @(negedge clk); end
    m_rd_valid = 0;
    if (!acc) chk(0, "R8 read granted", 0, 1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    bit done = 0;
    idle(4);
    rst = 0;
    idle(1);
    #1.5;
    chk(m_wr_ready == 1, "R11 ready after reset", m_wr_ready, 1);
    chk(mem_req == 0, "R11 no request after reset", mem_req, 0);
    chk(m_rd_rvalid == 0, "R11 no read data after reset", m_rd_rvalid, 0);
    @(negedge clk);

    // R1 R2 R5: posting without grant, full stall, oldest-first drain
    cmd_log.delete();
    for (int i = 0; i < 4; i++) wr(AW'(10 + i), 32'hA000_0000 + i, 4'b1111);
    #1.5;
    chk(cmd_log.size() == 0, "R1 acknowledged before any memory write", cmd_log.size(), 0);
    chk(m_wr_ready == 0, "R2 stall when full", m_wr_ready, 0);
    chk(mem_req && mem_we && mem_addr == 10, "R5 head presented first", mem_addr, 10);
    @(negedge clk); mem_gnt = 1;
    @(negedge clk); mem_gnt = 0;
    #1.5;
    chk(m_wr_ready == 1, "R2 ready after one drain", m_wr_ready, 1);
    @(negedge clk); mem_gnt = 1;
    idle(8);
    chk(cmd_log.size() == 4, "R5 drain count", cmd_log.size(), 4);
    for (int i = 0; i < 4 && i < cmd_log.size(); i++)
      chk(cmd_log[i].we && cmd_log[i].a == AW'(10 + i) && cmd_log[i].d == 32'hA000_0000 + i,
          "R5 drain order", cmd_log[i].a, 10 + i);

    // R3 R4: merge and collapse into one slot
    cmd_log.delete(); mem_gnt = 0;
    wr(20, 32'h0000_0011, 4'b0001);
    wr(20, 32'h0033_0000, 4'b0100);
    wr(20, 32'h0000_0055, 4'b0001);
    wr(21, 32'hDEAD_BEEF, 4'b1111);
    wr(22, 32'h1234_5678, 4'b1111);
    #1.5;
    chk(m_wr_ready == 1, "R3 merged writes share a slot", m_wr_ready, 1);
    @(negedge clk);
    wr(23, 32'h8765_4321, 4'b1111);
    #1.5;
    chk(m_wr_ready == 0, "R3 four slots in use", m_wr_ready, 0);
    @(negedge clk); mem_gnt = 1;
    idle(8);
    chk(cmd_log.size() == 4, "R3 one memory write per word", cmd_log.size(), 4);
    if (cmd_log.size() > 0) begin
      chk(cmd_log[0].a == 20 && cmd_log[0].be == 4'b0101, "R3 merged byte mask", cmd_log[0].be, 4'b0101);
      chk((cmd_log[0].d & 32'h00FF_00FF) == 32'h0033_0055, "R4 latest byte wins",
          cmd_log[0].d & 32'h00FF_00FF, 32'h0033_0055);
    end

    // R6: write to the head in its drain cycle takes a new entry
    cmd_log.delete(); mem_gnt = 0;
    wr(25, 32'h0000_00AA, 4'b0001);
    mem_gnt = 1;
    wr(25, 32'h0000_BB00, 4'b0010);
    idle(6);
    chk(cmd_log.size() == 2, "R6 two memory writes", cmd_log.size(), 2);
    if (cmd_log.size() == 2) begin
      chk(cmd_log[0].be == 4'b0001 && cmd_log[0].d[7:0] == 8'hAA, "R6 old entry first", cmd_log[0].be, 4'b0001);
      chk(cmd_log[1].be == 4'b0010 && cmd_log[1].d[15:8] == 8'hBB, "R6 new entry own mask", cmd_log[1].be, 4'b0010);
    end

    // R7 R8: read overtakes posted writes and sees their bytes
    cmd_log.delete(); mem_gnt = 0;
    wr(30, 32'h0000_EE00, 4'b0010);
    wr(31, 32'h7700_0000, 4'b1000);
    mem_gnt = 1;
    rd(30);
    rd(31);
    rd(33);
    idle(12);
    chk(cmd_log.size() > 0 && !cmd_log[0].we && cmd_log[0].a == 30, "R8 read before drain",
        cmd_log.size() > 0 ? cmd_log[0].we : 1'b1, 0);

    // R9: disabled buffer drains, then passes the write through ahead of the read
    cmd_log.delete(); mem_gnt = 0;
    wr(40, 32'h0102_0304, 4'b1111);
    wr(41, 32'h0000_ABCD, 4'b0011);
    buf_en = 0;
    fork
      wr(42, 32'h5A5A_5A5A, 4'b1111);
      rd(43);
      begin
        #1.5;
        chk(m_wr_ready == 0, "R9 no ack without grant", m_wr_ready, 0);
        chk(mem_req && mem_we && mem_addr == 40, "R9 leftover entry drains first", mem_addr, 40);
        @(negedge clk); mem_gnt = 1;
      end
    join
    idle(10);
    chk(cmd_log.size() == 4, "R9 command count", cmd_log.size(), 4);
    if (cmd_log.size() == 4) begin
      chk(cmd_log[2].we && cmd_log[2].a == 42, "R9 pass-through write", cmd_log[2].a, 42);
      chk(!cmd_log[3].we && cmd_log[3].a == 43, "R9 read after write", cmd_log[3].a, 43);
    end
    buf_en = 1;

    // Random traffic over a few words with an irregular grant
    fork
      begin
        for (int i = 0; i < 300; i++) begin
          wr(AW'($urandom_range(0, 7)), $urandom, 4'($urandom_range(1, 15)));
          if ($urandom_range(0, 3) == 0) @(negedge clk);
        end
        done = 1;
      end
      begin
        for (int i = 0; i < 100; i++) begin
          rd(AW'($urandom_range(0, 7)));
          repeat ($urandom_range(0, 4)) @(negedge clk);
        end
      end
      begin
        while (!done) begin
          mem_gnt = ($urandom_range(0, 9) < 6);
          @(negedge clk);
        end
        mem_gnt = 1;
      end
    join
    idle(30);
    for (int i = 0; i < WORDS; i++)
      chk(bmem[i] == gold[i], "R5 memory image after drain", bmem[i], gold[i]);
    chk(exp_q.size() == 0, "R7 every read returned", exp_q.size(), 0);
    finish_run();
  end
endmodule